// File: doc/BRIEF.md
# Multiplexed Byte-Wide Parallel Write Sequencer

This block turns one 32-bit write request into a bus transaction on a 16-bit multiplexed address/data bus toward an asynchronous memory or memory-mapped peripheral. A request carries a 16-bit base address and four data bytes. The sequencer first shows the whole address on the bus while an address-latch strobe is active, so an external latch can capture it. It then performs a burst of exactly four byte writes. During each write the upper bus byte repeats the high address byte and the lower bus byte carries one data byte, framed by an active-low write strobe.

Bus timing is counted in peripheral cycles, and each peripheral cycle is two core clock cycles. The width of the write strobe and the spacing between strobes depend on a 5-bit duration setting, an optional hold cycle and a flash-mode stretch, all taken from the configuration inputs when a request is accepted. Requests use a valid/ready handshake. A one-cycle completion pulse marks the end of the burst.

Top module: `mux8_write_seq`

## Requirements
- R1: After reset, req_ready is 1, wr_n is 1, rd_n is 1, ad_oe is 0, done is 0 and the latch strobe is at its inactive level.
- R2: A request is taken only when req_valid and req_ready are both 1 at a clock edge. req_ready stays 0 from acceptance until the burst ends, and a req_valid raised while busy causes no extra bus activity.
- R3: The latch strobe is active for 2 peripheral cycles (4 core cycles) with the full 16-bit address on ad_out. The address stays on ad_out for 1 more peripheral cycle after the strobe goes inactive.
- R4: The first wr_n falling edge comes 2 peripheral cycles after the latch strobe goes inactive, and wr_n is never low while the latch strobe is active.
- R5: Each request gives exactly four write strobes, in byte order req_data[7:0], [15:8], [23:16], [31:24]. During each one ad_out = {req_addr[15:8], byte}, and ad_out does not change while wr_n is low.
- R6: wr_n stays low for (D − F) peripheral cycles. D is cfg_dur, and a value of 0 is used as 1.
- R7: From one wr_n rising edge to the next falling edge there are F + H + 1 peripheral cycles, with H = 1 when cfg_hold is 1 and 0 otherwise. The current byte stays on ad_out for H peripheral cycles after wr_n rises.
- R8: With cfg_flash = 1, F = 7 and any D below 9 is raised to 9. With cfg_flash = 0, F = 0.
- R9: done is a single-cycle pulse that occurs H peripheral cycles after the fourth wr_n rising edge. req_ready is 1 in that same cycle.
- R10: With cfg_ale_low = 0 the latch strobe ale is active high. With cfg_ale_low = 1 it is active low, so it rests at 1 when idle.
- R11: rd_n is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 16 | Base address of the request |
| req_data | input | 32 | Four data bytes, lowest byte written first |
| cfg_dur | input | 5 | Data-cycle duration D in peripheral cycles |
| cfg_hold | input | 1 | Adds one hold peripheral cycle after each strobe |
| cfg_flash | input | 1 | Flash mode: 7-cycle stretch, minimum D of 9 |
| cfg_ale_low | input | 1 | Makes the latch strobe active low |
| ad_out | output | 16 | Multiplexed address/data bus |
| ad_oe | output | 1 | Bus drive enable, 1 while a burst runs |
| ale | output | 1 | Address latch strobe |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe, held inactive |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The hardest case to reach from the ports is a request that arrives while a burst is already running. The block must leave it alone without any trace on the bus. The stimulus raises req_valid with an unrelated address partway through a burst and holds it for several cycles. The bench confirms that req_ready stays low the whole time, and the scoreboard then confirms that no fifth strobe and no second latch phase appear. Flash-mode clamping is reached by programming a duration below the minimum, and the bench checks that the measured strobe width reflects the raised value.

// File: rtl/mux8_write_seq.sv
module mux8_write_seq #(
  parameter int AW        = 16,
  parameter int DUR_W     = 5,
  parameter int NB        = 4,
  parameter int PDIV      = 2,
  parameter int ALE_PC    = 2,
  parameter int FLASH_EXT = 7,
  parameter int FLASH_MIN = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [NB*8-1:0]  req_data,
  input  logic [DUR_W-1:0] cfg_dur,
  input  logic             cfg_hold,
  input  logic             cfg_flash,
  input  logic             cfg_ale_low,
  output logic [AW-1:0]    ad_out,
  output logic             ad_oe,
  output logic             ale,
  output logic             wr_n,
  output logic             rd_n,
  output logic             done
);
  localparam int CNT_W = $clog2((1 << DUR_W) * PDIV + FLASH_EXT * PDIV + 1);
  localparam int IW    = (NB > 1) ? $clog2(NB) : 1;
  localparam int NW_W  = $clog2(NB + 1);

  typedef enum logic [2:0] {S_IDLE, S_ALE, S_AHLD, S_SETUP, S_WR, S_HOLD, S_GAP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [IW-1:0]    idx;
  logic [AW-1:0]    addr_q;
  logic [NB*8-1:0]  data_q;
  logic [DUR_W-1:0] dw_q;
  logic             hold_q, flash_q, done_q;
  logic [DUR_W-1:0] d_eff;
  logic             last;

  function automatic logic [CNT_W-1:0] plen(input int n);
    return CNT_W'(n * PDIV - 1);
  endfunction

  always_comb begin
    if (cfg_flash)
      d_eff = (cfg_dur < DUR_W'(FLASH_MIN)) ? DUR_W'(FLASH_MIN) : cfg_dur;
    else
      d_eff = (cfg_dur == '0) ? DUR_W'(1) : cfg_dur;
  end

  assign last = (idx == IW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      dw_q    <= '0;
      hold_q  <= 1'b0;
      flash_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          st      <= S_ALE;
          cnt     <= plen(ALE_PC);
          idx     <= '0;
          addr_q  <= req_addr;
          data_q  <= req_data;
          dw_q    <= d_eff - (cfg_flash ? DUR_W'(FLASH_EXT) : DUR_W'(0));
          hold_q  <= cfg_hold;
          flash_q <= cfg_flash;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        unique case (st)
          S_ALE:   begin st <= S_AHLD;  cnt <= plen(1); end
          S_AHLD:  begin st <= S_SETUP; cnt <= plen(1); end
          S_SETUP: begin st <= S_WR;    cnt <= plen(int'(dw_q)); end
          S_WR: begin
            if (hold_q) begin
              st  <= S_HOLD;
              cnt <= plen(1);
            end else if (last) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st  <= S_GAP;
              idx <= idx + 1'b1;
              cnt <= plen(flash_q ? FLASH_EXT + 1 : 1);
            end
          end
          S_HOLD: begin
            if (last) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st  <= S_GAP;
              idx <= idx + 1'b1;
              cnt <= plen(flash_q ? FLASH_EXT + 1 : 1);
            end
          end
          S_GAP:   begin st <= S_WR; cnt <= plen(int'(dw_q)); end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign req_ready = (st == S_IDLE);
  assign ad_oe     = (st != S_IDLE);
  assign ale       = cfg_ale_low ^ (st == S_ALE);
  assign wr_n      = (st != S_WR);
  assign rd_n      = 1'b1;
  assign done      = done_q;

  always_comb begin
    if (st == S_IDLE)
      ad_out = '0;
    else if (st == S_ALE || st == S_AHLD)
      ad_out = addr_q;
    else
      ad_out = {addr_q[AW-1:8], data_q[idx*8 +: 8]};
  end

  logic            ale_act, wr_n_d;
  logic [NW_W-1:0] nwr;
  assign ale_act = ale ^ cfg_ale_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_d <= 1'b1;
      nwr    <= '0;
    end else begin
      wr_n_d <= wr_n;
      if (ale_act) nwr <= '0;
      else if (wr_n_d && !wr_n) nwr <= nwr + 1'b1;
    end
  end

  AST_RD_IDLE:      assert property (@(posedge clk) disable iff (!rst_n) rd_n);                                   // R11
  AST_STROBE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(ale_act && !wr_n));                   // R4
  AST_AD_STABLE:    assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !wr_n_d) |-> $stable(ad_out)); // R5
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                       // R9
  AST_DONE_READY:   assert property (@(posedge clk) disable iff (!rst_n) done |-> req_ready);                   // R9
  AST_BUSY_BLOCK:   assert property (@(posedge clk) disable iff (!rst_n) ad_oe |-> !req_ready);                 // R2
  AST_GROUP_FULL:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (nwr == NW_W'(NB)));          // R5
  AST_GROUP_START:  assert property (@(posedge clk) disable iff (!rst_n)
                                     $rose(ale_act) |-> (nwr == '0 || nwr == NW_W'(NB)));                        // R5
endmodule

// File: tb/mux8_write_seq_tb_top.sv
`timescale 1ns/1ps
module mux8_write_seq_tb_top;
  localparam int P = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [4:0]  cfg_dur = 5'd3;
  logic        cfg_hold = 1'b0, cfg_flash = 1'b0, cfg_ale_low = 1'b0;
  logic [15:0] ad_out;
  logic        ad_oe, ale, wr_n, rd_n, done;

  always #4 clk = ~clk;

  mux8_write_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .cfg_dur(cfg_dur), .cfg_hold(cfg_hold),
    .cfg_flash(cfg_flash), .cfg_ale_low(cfg_ale_low), .ad_out(ad_out), .ad_oe(ad_oe),
    .ale(ale), .wr_n(wr_n), .rd_n(rd_n), .done(done)
  );

  typedef struct {
    logic [15:0] ad;
    int width, gap, hold;
    bit first, last;
  } wexp_t;

  wexp_t       wq[$];
  logic [15:0] aq[$];
  int errors = 0, checks = 0, done_cnt = 0;
  logic pol = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  int cyc = 0, t_as = 0, t_ae = 0, t_f = 0, t_r = -100000, hold_left = 0;
  bit ale_prev = 0, wr_prev = 1, done_prev = 0, last_flag = 0, in_grp = 0;
  logic [15:0] cur_addr = '0, last_ad = '0;
  wexp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit aa = ale ^ pol;
      cyc++;
      if (!rd_n) chk(0, "R11", "rd_n low", rd_n, 1);
      if (aa && !ale_prev) begin
        t_as = cyc;
        if (aq.size() == 0) chk(0, "R2", "unexpected latch phase", 1, 0);
        else begin
          cur_addr = aq.pop_front();
          chk(ad_out == cur_addr, "R3", "address during latch", ad_out, cur_addr);
        end
        in_grp = 1;
      end
      if (!aa && ale_prev) begin
        t_ae = cyc;
        chk(t_ae - t_as == 2*P, "R3", "latch strobe width", t_ae - t_as, 2*P);
      end
      if (!aa && in_grp && wr_n && (cyc - t_ae) < P && !ale_prev == 0)
        ;
      if (!aa && in_grp && wr_n && (cyc - t_ae) >= 0 && (cyc - t_ae) < P && t_ae > t_as)
        chk(ad_out == cur_addr, "R3", "address hold after latch", ad_out, cur_addr);
      if (!wr_n && wr_prev) begin
        t_f = cyc;
        if (wq.size() == 0) chk(0, "R2", "unexpected write strobe", 1, 0);
        else begin
          cur = wq[0];
          chk(ad_out == cur.ad, "R5", "bus value at strobe", ad_out, cur.ad);
          if (cur.first) chk(t_f - t_ae == 2*P, "R4", "latch end to first strobe", t_f - t_ae, 2*P);
          else           chk(t_f - t_r == cur.gap, "R7", "strobe gap", t_f - t_r, cur.gap);
          in_grp = 0;
        end
      end
      if (wr_n && !wr_prev && wq.size() != 0) begin
        cur = wq.pop_front();
        t_r = cyc;
        chk(t_r - t_f == cur.width, "R6", "strobe width", t_r - t_f, cur.width);
        last_ad = cur.ad; hold_left = cur.hold; last_flag = cur.last;
      end
      if (wr_n && (cyc - t_r) < hold_left)
        chk(ad_out == last_ad, "R7", "byte held after strobe", ad_out, last_ad);
      if (done) begin
        chk(last_flag && (cyc - t_r) == hold_left, "R9", "done timing", cyc - t_r, hold_left);
        chk(!done_prev, "R9", "done longer than one cycle", done_prev, 0);
        done_cnt++;
      end
      ale_prev = aa; wr_prev = wr_n; done_prev = done;
    end
  end

  task automatic send(input logic [15:0] a, input logic [31:0] d, input int dur,
                      input bit h, input bit fl, input bit pl, input bit poke);
    int f, de, d0;
    f  = fl ? 7 : 0;
    de = fl ? (dur < 9 ? 9 : dur) : (dur == 0 ? 1 : dur);
    for (int i = 0; i < 4; i++) begin
      wexp_t e;
      e.ad = {a[15:8], d[i*8 +: 8]};
      e.width = (de - f) * P;
      e.gap = (f + (h ? 1 : 0) + 1) * P;
      e.hold = (h ? 1 : 0) * P;
      e.first = (i == 0);
      e.last = (i == 3);
      wq.push_back(e);
    end
    aq.push_back(a);
    @(negedge clk); #2;
    cfg_dur = 5'(dur); cfg_hold = h; cfg_flash = fl; cfg_ale_low = pl; pol = pl;
    while (!req_ready) begin @(negedge clk); #2; end
    d0 = done_cnt;
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      #2 req_valid = 1'b1; req_addr = 16'hDEAD; req_data = 32'hFFFF_FFFF;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
      end
      #2 req_valid = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready at done", req_ready, 1);
    repeat (3) @(negedge clk);
    chk(wq.size() == 0, "R5", "four strobes consumed", wq.size(), 0);
    chk(wr_n && !ad_oe, "R2", "bus released", ad_oe, 0);
    chk(ale == pl, "R10", "latch strobe idle level", ale, pl);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
    chk(wr_n == 1 && rd_n == 1, "R1", "reset strobes", wr_n, 1);
    chk(ad_oe == 0 && done == 0, "R1", "reset oe/done", ad_oe, 0);
    chk(ale == 0, "R1", "reset latch strobe", ale, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(16'h12A4, 32'h4433_2211, 3,  0, 0, 0, 0);   // R6 basic
    send(16'hBEEF, 32'hDDCC_BBAA, 5,  1, 0, 0, 1);   // R7 hold, R2 busy poke
    send(16'h0F0F, 32'h0102_0304, 0,  0, 0, 0, 0);   // R6 zero duration
    send(16'h7700, 32'hCAFE_F00D, 12, 1, 1, 0, 0);   // R8 flash
    send(16'h8001, 32'h5566_7788, 4,  0, 1, 1, 0);   // R8 clamp, R10 active low
    send(16'hFFFF, 32'h0000_00FF, 31, 1, 0, 1, 0);   // R6 max duration
    send(16'h0102, 32'h99AA_BBCC, 2,  1, 0, 0, 0);   // R10 back to active high
    repeat (20) @(negedge clk);
    chk(aq.size() == 0, "R2", "no leftover latch phases", aq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule